// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a serial test port for a memory device. It runs the usual sixteen-state test controller from a test clock and a mode-select line. It routes one of four serial registers between the data input and the data output: a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identity word, or a boundary register whose width is a parameter. The boundary register captures a parallel vector supplied by the surrounding logic.

The block has no reset pin. The controller and the instruction come up in their reset values at power-on. Holding the mode-select line high for five rising clock edges returns the port to its reset state from anywhere. Some instruction codes ask the functional outputs of the device to float. The block reports this on a single force line.

Serial output is registered on the falling test clock edge. It comes with a drive-enable signal, so the pad logic can float the pin when no shift is under way.

Top module: `scan_tap`

## Requirements
- R1: At power-on the controller is in Test-Logic-Reset and the instruction is IDCODE (001). `tdo_en`, `tdo` and `hiz_force` are all low.
- R2: Five consecutive rising edges with `tms` high put the controller in Test-Logic-Reset from any state. Entering that state reloads the instruction with 001 at the same edge.
- R3: State moves follow the standard sixteen-state boundary-scan graph, driven by `tms` sampled on the rising edge.
- R4: `tms` and `tdi` are sampled on rising `tck`. `tdo` and `tdo_en` change only on falling `tck`. `tdo_en` is high exactly while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.
- R5: With instruction 001, Capture-DR loads {revision[3:0], part[15:0], vendor[10:0], 1}. Shift-DR then sends bit 0 first, and `tdi` enters at bit 31.
- R6: Capture-IR loads 001 into the instruction shift stage, so the first bits shifted out are 1, 0, 0. The shift stage takes `tdi` at bit 2 and sends bit 0 first. The active instruction changes only in Update-IR, or on entry to Test-Logic-Reset.
- R7: Codes 011, 101, 110 and 111 select a 1-bit bypass stage. It captures 0, so the data appears at `tdo` delayed by one shift. `hiz_force` stays low.
- R8: Code 100 selects the boundary register. Capture-DR loads `bnd_in`, and bit 0 is shifted out first. `hiz_force` stays low.
- R9: Codes 000 and 010 also select the boundary register, with the same capture and shift as R8. `hiz_force` is high for as long as either code is the active instruction.
- R10: Passing through Exit1-DR, Pause-DR and Exit2-DR and back into Shift-DR keeps the partly shifted data. Shifting resumes at the next bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bnd_in | input | BND_W | Parallel vector captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Drive enable for `tdo` |
| hiz_force | output | 1 | Request to float the functional outputs |

## Verification
The bench builds the block with a 12-bit boundary register and nonzero identity fields of distinct values. With these settings, a misplaced revision, part or vendor field, or a dropped bit of a wide capture vector, shows up in a serial readout. The width also differs from both the 3-bit instruction stage and the 32-bit identity word, so a mix-up between shift paths changes the shift length seen at `tdo`. Every instruction code is loaded at least once. Early termination by five high mode-select edges is entered from Pause-DR while a force-float code is active. A pause in the middle of a shift is checked to hold the data.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          BND_W   = 8,
  parameter logic [3:0]  ID_REV  = 4'h3,
  parameter logic [15:0] ID_PART = 16'h6B40,
  parameter logic [10:0] ID_VEND = 11'h090
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BND_W-1:0] bnd_in,
  output logic             tdo,
  output logic             tdo_en,
  output logic             hiz_force
);
  localparam logic [31:0] ID_WORD = {ID_REV, ID_PART, ID_VEND, 1'b1};
  localparam logic [2:0]  OP_EXT  = 3'b000;
  localparam logic [2:0]  OP_ID   = 3'b001;
  localparam logic [2:0]  OP_SZ   = 3'b010;
  localparam logic [2:0]  OP_SMP  = 3'b100;

  typedef enum logic [3:0] {
    S_TLR = 4'd0,  S_RTI = 4'd1,  S_SELDR = 4'd2, S_CAPDR = 4'd3,
    S_SHDR = 4'd4, S_EX1DR = 4'd5, S_PADR = 4'd6, S_EX2DR = 4'd7,
    S_UPDDR = 4'd8, S_SELIR = 4'd9, S_CAPIR = 4'd10, S_SHIR = 4'd11,
    S_EX1IR = 4'd12, S_PAIR = 4'd13, S_EX2IR = 4'd14, S_UPDIR = 4'd15
  } tap_st_t;

  tap_st_t          st = S_TLR;
  tap_st_t          nxt;
  logic [2:0]       ir = OP_ID;
  logic [2:0]       ir_sh = 3'b000;
  logic [31:0]      id_sh = '0;
  logic [BND_W-1:0] bnd_sh = '0;
  logic             byp = 1'b0;
  logic             tdo_q = 1'b0;
  logic             en_q = 1'b0;

  wire sel_id  = (ir == OP_ID);
  wire sel_bnd = (ir == OP_EXT) || (ir == OP_SZ) || (ir == OP_SMP);

  assign hiz_force = (ir == OP_EXT) || (ir == OP_SZ);
  assign tdo       = tdo_q;
  assign tdo_en    = en_q;

  always_comb begin
    case (st)
      S_TLR:   nxt = tms ? S_TLR   : S_RTI;
      S_RTI:   nxt = tms ? S_SELDR : S_RTI;
      S_SELDR: nxt = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nxt = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nxt = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nxt = tms ? S_UPDDR : S_PADR;
      S_PADR:  nxt = tms ? S_EX2DR : S_PADR;
      S_EX2DR: nxt = tms ? S_UPDDR : S_SHDR;
      S_UPDDR: nxt = tms ? S_SELDR : S_RTI;
      S_SELIR: nxt = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nxt = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nxt = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nxt = tms ? S_UPDIR : S_PAIR;
      S_PAIR:  nxt = tms ? S_EX2IR : S_PAIR;
      S_EX2IR: nxt = tms ? S_UPDIR : S_SHIR;
      default: nxt = tms ? S_SELDR : S_RTI;
    endcase
  end

  always_ff @(posedge tck) begin
    st <= nxt;
    if (nxt == S_TLR) ir <= OP_ID;
    else if (st == S_UPDIR) ir <= ir_sh;
    case (st)
      S_CAPIR: ir_sh <= 3'b001;
      S_SHIR:  ir_sh <= {tdi, ir_sh[2:1]};
      default: ;
    endcase
    if (st == S_CAPDR) begin
      byp <= 1'b0;
      if (sel_id)  id_sh  <= ID_WORD;
      if (sel_bnd) bnd_sh <= bnd_in;
    end else if (st == S_SHDR) begin
      byp    <= tdi;
      id_sh  <= {tdi, id_sh[31:1]};
      bnd_sh <= {tdi, bnd_sh[BND_W-1:1]};
    end
  end

  always_ff @(negedge tck) begin
    en_q <= (st == S_SHIR) || (st == S_SHDR);
    if (st == S_SHIR)      tdo_q <= ir_sh[0];
    else if (st != S_SHDR) tdo_q <= 1'b0;
    else if (sel_id)       tdo_q <= id_sh[0];
    else if (sel_bnd)      tdo_q <= bnd_sh[0];
    else                   tdo_q <= byp;
  end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk (
  input logic       tck,
  input logic       tms,
  input logic       tdo_en,
  input logic       hiz_force,
  input logic [3:0] st,
  input logic [2:0] ir,
  input logic [2:0] ir_sh
);
  localparam logic [3:0] C_TLR = 4'd0, C_SHDR = 4'd4, C_SELIR = 4'd9,
                         C_CAPIR = 4'd10, C_SHIR = 4'd11, C_UPDIR = 4'd15;
  logic       warm = 1'b0;
  logic [2:0] ones = 3'd0;

  always_ff @(posedge tck) begin
    warm <= 1'b1;
    if (!tms) ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  p_reset_loads_id_r2: assert property (@(posedge tck) disable iff (!warm)
    (st == C_TLR) |-> (ir == 3'b001));
  p_five_high_r2: assert property (@(posedge tck) disable iff (!warm)
    (ones == 3'd5) |-> (st == C_TLR));
  p_ir_holds_r6: assert property (@(posedge tck) disable iff (!warm)
    (st != C_UPDIR && st != C_SELIR) |=> $stable(ir));
  p_capture_ir_r6: assert property (@(posedge tck) disable iff (!warm)
    (st == C_CAPIR) |=> (ir_sh[1:0] == 2'b01));
  p_enable_in_shift_r4: assert property (@(posedge tck) disable iff (!warm)
    tdo_en |-> (st == C_SHIR || st == C_SHDR));
  p_float_on_sz_r9: assert property (@(posedge tck) disable iff (!warm)
    (st == C_UPDIR && ir_sh == 3'b010) |=> hiz_force);
endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck(tck), .tms(tms), .tdo_en(tdo_en), .hiz_force(hiz_force),
  .st(st), .ir(ir), .ir_sh(ir_sh)
);

// File: tb/scan_tap_tb_top.sv
`timescale 1ns/100ps
module scan_tap_tb_top;
  localparam int          BW   = 12;
  localparam logic [3:0]  REV  = 4'hA;
  localparam logic [15:0] PART = 16'h5C3E;
  localparam logic [10:0] VEND = 11'h2B5;
  localparam logic [31:0] IDW  = {REV, PART, VEND, 1'b1};

  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                 PADR = 6, EX2DR = 7, UPDDR = 8, SELIR = 9, CAPIR = 10,
                 SHIR = 11, EX1IR = 12, PAIR = 13, EX2IR = 14, UPDIR = 15;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BW-1:0] bnd_in = '0;
  logic tdo, tdo_en, hiz_force;

  scan_tap #(.BND_W(BW), .ID_REV(REV), .ID_PART(PART), .ID_VEND(VEND)) dut_i (
    .tck(tck), .tms(tms), .tdi(tdi), .bnd_in(bnd_in),
    .tdo(tdo), .tdo_en(tdo_en), .hiz_force(hiz_force));

  always #2 tck = ~tck;

  int total = 0, bad = 0;
  string cur_req = "R3";
  int ms = TLR;
  int m_ir = 1;
  bit irq[$];
  bit drq[$];
  bit m_tdo = 0, m_en = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int step_state(input int s, input bit m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      SELIR: return m ? TLR : CAPIR;
      CAPDR, SHDR: return m ? EX1DR : SHDR;
      CAPIR, SHIR: return m ? EX1IR : SHIR;
      EX1DR: return m ? UPDDR : PADR;
      EX1IR: return m ? UPDIR : PAIR;
      PADR: return m ? EX2DR : PADR;
      PAIR: return m ? EX2IR : PAIR;
      EX2DR: return m ? UPDDR : SHDR;
      EX2IR: return m ? UPDIR : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  task automatic model_rise(input bit m, input bit d);
    int nx = step_state(ms, m);
    if (ms == CAPIR) irq = '{1'b1, 1'b0, 1'b0};
    else if (ms == SHIR) begin void'(irq.pop_front()); irq.push_back(d); end
    else if (ms == UPDIR) m_ir = 4*int'(irq[2]) + 2*int'(irq[1]) + int'(irq[0]);
    else if (ms == CAPDR) begin
      drq.delete();
      if (m_ir == 1) for (int k = 0; k < 32; k++) drq.push_back(IDW[k]);
      else if (m_ir == 0 || m_ir == 2 || m_ir == 4)
        for (int k = 0; k < BW; k++) drq.push_back(bnd_in[k]);
      else drq.push_back(1'b0);
    end else if (ms == SHDR) begin void'(drq.pop_front()); drq.push_back(d); end
    if (nx == TLR) m_ir = 1;
    ms = nx;
  endtask

  task automatic tick(input bit m, input bit d);
    tms = m; tdi = d;
    @(posedge tck);
    model_rise(m, d);
    @(negedge tck);
    m_en  = (ms == SHIR) || (ms == SHDR);
    m_tdo = !m_en ? 1'b0 : (ms == SHIR) ? irq[0] : drq[0];
    #0.5;
    chk(cur_req, {61'd0, tdo, tdo_en, hiz_force},
        {61'd0, m_tdo, m_en, (m_ir == 0 || m_ir == 2)});
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0]  cap;
    logic [63:0] got;
    #1;
    chk("R1 tdo_en", {63'd0, tdo_en}, 64'd0);
    chk("R1 tdo", {63'd0, tdo}, 64'd0);
    chk("R1 hiz_force", {63'd0, hiz_force}, 64'd0);

    cur_req = "R3";
    tick(0, 0); tick(0, 0); tick(1, 0); tick(1, 0); tick(1, 0); tick(0, 0);
    chk("R3 idle after loop", {63'd0, tdo_en}, 64'd0);

    cur_req = "R5";
    scan_dr(32, 64'h0000_0000_C3A5_0F1E, got);
    chk("R5 identity word", got, {32'd0, IDW});

    cur_req = "R6";
    load_ir(3'b100, cap);
    chk("R6 capture-IR pattern", {61'd0, cap}, 64'd1);
    chk("R8 no float on sample", {63'd0, hiz_force}, 64'd0);

    cur_req = "R8";
    bnd_in = 12'hA5C;
    scan_dr(BW, 64'h3F0, got);
    chk("R8 boundary capture", got, 64'hA5C);
    bnd_in = 12'h0F3;
    scan_dr(BW, 64'hFFF, got);
    chk("R8 second capture", got, 64'h0F3);

    cur_req = "R9";
    load_ir(3'b000, cap);
    chk("R9 float on 000", {63'd0, hiz_force}, 64'd1);
    bnd_in = 12'h861;
    scan_dr(BW, 64'h0, got);
    chk("R9 sample under 000", got, 64'h861);
    load_ir(3'b010, cap);
    chk("R9 float on 010", {63'd0, hiz_force}, 64'd1);
    bnd_in = 12'h7E2;
    scan_dr(BW, 64'h555, got);
    chk("R9 boundary under 010", got, 64'h7E2);

    cur_req = "R7";
    for (int c = 0; c < 4; c++) begin
      logic [2:0] code;
      code = (c == 0) ? 3'b011 : (c == 1) ? 3'b101 : (c == 2) ? 3'b110 : 3'b111;
      load_ir(code, cap);
      chk("R7 no float on bypass", {63'd0, hiz_force}, 64'd0);
      scan_dr(8, 64'hB2, got);
      chk("R7 one-stage delay", got, 64'h64);
    end

    cur_req = "R10";
    load_ir(3'b001, cap);
    got = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 10; i++) begin
      got[i] = tdo;
      tick(i == 9, 0);
    end
    tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int i = 10; i < 32; i++) begin
      got[i] = tdo;
      tick(i == 31, 0);
    end
    tick(1, 0); tick(0, 0);
    chk("R10 pause keeps data", got, {32'd0, IDW});

    cur_req = "R2";
    load_ir(3'b010, cap);
    tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) tick(1, 0);
    chk("R2 float before fifth edge", {63'd0, hiz_force}, 64'd1);
    tick(1, 0);
    chk("R2 idcode after fifth edge", {63'd0, hiz_force}, 64'd0);
    tick(0, 0);
    scan_dr(32, 64'h0, got);
    chk("R2 identity after reset", got, {32'd0, IDW});

    cur_req = "R4";
    tick(0, 0);
    chk("R4 no drive in idle", {62'd0, tdo, tdo_en}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule